// File: doc/BRIEF.md
# NAND Status Poller with Bounded Retry

This block runs the "wait until the flash is ready" step that reset-detect, parameter-read and program/erase sequences all need. A sequencer pulses `start_i`. The block then writes the status-read command byte once on the command-latch path. After that it keeps issuing plain data reads and inspects each returned status byte until the device reports ready. When the device reports ready, the block also checks the device's own error flag.

The block ends every poll with a one-cycle done pulse and a two-bit outcome: pass, fail, or timeout. Timeout means the device never became ready within a parameterised number of reads. The last status byte sampled is held on an output for debug. Bus timing on the pins and ready/busy pin sensing belong to the bus adapter, not to this block.

Top module: `nand_status_poll`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_we_o`, `rd_o`, `busy_o` and `done_o` are 0, `result_o` is 2'b00 and `last_status_o` is 8'h00.
- R2: The cycle after `start_i` is sampled in idle, `cmd_we_o` is high for exactly one cycle carrying `cmd_byte_o` = 8'h70. No further command is issued during that poll.
- R3: The first `rd_o` pulse comes the cycle after the command cycle. `rd_data_i` is sampled in the cycle that follows each `rd_o` pulse. When another read is needed, the next `rd_o` pulse comes in the cycle after that sample, so reads are one cycle long and two cycles apart.
- R4: A sampled byte with bit 6 = 1 means ready. If bit 0 = 0 in that byte, the poll ends with `result_o` = 2'b00 (pass).
- R5: A ready byte with bit 0 = 1 ends the poll with `result_o` = 2'b01 (fail).
- R6: If POLL_LIMIT reads have all returned bit 6 = 0, the poll ends with `result_o` = 2'b10 (timeout). In that case exactly POLL_LIMIT `rd_o` pulses were issued, and the read counter never exceeds POLL_LIMIT.
- R7: `done_o` is a single-cycle pulse in the cycle after the deciding sample. A poll of n reads therefore finishes 2n+2 cycles after `start_i` is sampled. `result_o` is valid only while `done_o` is high and reads 2'b00 at all other times.
- R8: Bits 1 to 5 and bit 7 of the status byte have no effect on the outcome. `last_status_o` holds the most recently sampled byte, all eight bits, until the next sample.
- R9: A `start_i` pulse while a poll is in progress is ignored: no second command is issued, and the running poll's read count and outcome are unchanged.
- R10: `busy_o` is high from the command cycle through the done cycle inclusive and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe from the sequencer |
| cmd_we_o | output | 1 | Command-latch write strobe |
| cmd_byte_o | output | 8 | Command byte, 8'h70 while `cmd_we_o` is high |
| rd_o | output | 1 | Data-read strobe |
| rd_data_i | input | 8 | Status byte returned, valid the cycle after `rd_o` |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 00 pass, 01 fail, 10 timeout; valid with `done_o` |
| last_status_o | output | 8 | Most recently sampled status byte |

## Verification
The bench sweeps the read on which ready first appears over every position from the first read to the last allowed one. It covers both settings of the error flag and fills the unrelated status bits with varied noise, so a design that decoded the wrong bit or let noise leak into the outcome would report the wrong result. The never-ready case checks the exact read count and finishing cycle: an off-by-one limit compare would show up as one read too many or too few, and would finish two cycles early or late. A second start pulse in the middle of a poll catches a design that re-issues the command or restarts its counter. Checks on the idle cycle after each poll catch a done pulse that lingers or an outcome that shows outside the done cycle.

// File: rtl/nsp_pkg.sv
package nsp_pkg;

  localparam int NSP_BUS_W     = 8;
  localparam int NSP_READY_BIT = 6;
  localparam int NSP_ERR_BIT   = 0;
  localparam logic [NSP_BUS_W-1:0] NSP_CMD_STATUS = 8'h70;

  typedef enum logic [1:0] {
    RES_PASS    = 2'b00,
    RES_FAIL    = 2'b01,
    RES_TIMEOUT = 2'b10
  } nsp_result_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CMD  = 3'd1,
    ST_READ = 3'd2,
    ST_EVAL = 3'd3,
    ST_DONE = 3'd4
  } nsp_state_e;

  function automatic logic status_ready(input logic [NSP_BUS_W-1:0] s);
    return s[NSP_READY_BIT];
  endfunction

  function automatic logic status_error(input logic [NSP_BUS_W-1:0] s);
    return s[NSP_ERR_BIT];
  endfunction

  // Outcome of a ready byte; only meaningful when status_ready() is true.
  function automatic nsp_result_e ready_outcome(input logic [NSP_BUS_W-1:0] s);
    return status_error(s) ? RES_FAIL : RES_PASS;
  endfunction

  // Cycles from the start sample to the done cycle for a poll of n reads.
  function automatic int poll_cycles(input int n);
    return 2 * n + 2;
  endfunction

endpackage

// File: rtl/nsp_poll_ctr.sv
module nsp_poll_ctr #(
  parameter int POLL_LIMIT = 100000,
  localparam int CW = $clog2(POLL_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] count_o,
  output logic          at_limit_o
);

  localparam logic [CW-1:0] LIMIT_V = CW'(POLL_LIMIT);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          count_q <= '0;
    else if (clr_i)      count_q <= '0;
    else if (inc_i)      count_q <= count_q + 1'b1;
  end

  assign count_o    = count_q;
  assign at_limit_o = (count_q == LIMIT_V);

  // R6: the read count never passes the limit
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= LIMIT_V);

  // R6: a read is never issued once the limit has been reached
  p_no_inc_at_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |-> !at_limit_o);

endmodule

// File: rtl/nsp_status_eval.sv
module nsp_status_eval
  import nsp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_i,
  input  logic [NSP_BUS_W-1:0] data_i,
  output logic                 ready_o,
  output nsp_result_e          outcome_o,
  output logic [NSP_BUS_W-1:0] last_o
);

  logic [NSP_BUS_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        last_q <= '0;
    else if (sample_i) last_q <= data_i;
  end

  assign ready_o   = status_ready(data_i);
  assign outcome_o = ready_outcome(data_i);
  assign last_o    = last_q;

  // R8: the debug byte only changes on a sample
  p_last_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_i |=> $stable(last_q));

endmodule

// File: rtl/nsp_fsm.sv
module nsp_fsm
  import nsp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        ready_i,
  input  nsp_result_e outcome_i,
  input  logic        at_limit_i,
  output logic        cmd_we_o,
  output logic        rd_o,
  output logic        sample_o,
  output logic        clr_o,
  output logic        busy_o,
  output logic        done_o,
  output nsp_result_e result_o
);

  nsp_state_e  state_q, state_d;
  nsp_result_e result_q, result_d;

  always_comb begin
    state_d  = state_q;
    result_d = result_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_CMD;
      ST_CMD:  state_d = ST_READ;
      ST_READ: state_d = ST_EVAL;
      ST_EVAL: begin
        if (ready_i) begin
          state_d  = ST_DONE;
          result_d = outcome_i;
        end else if (at_limit_i) begin
          state_d  = ST_DONE;
          result_d = RES_TIMEOUT;
        end else begin
          state_d = ST_READ;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      result_q <= RES_PASS;
    end else begin
      state_q  <= state_d;
      result_q <= result_d;
    end
  end

  assign cmd_we_o = (state_q == ST_CMD);
  assign rd_o     = (state_q == ST_READ);
  assign sample_o = (state_q == ST_EVAL);
  assign done_o   = (state_q == ST_DONE);
  assign busy_o   = (state_q != ST_IDLE);
  assign clr_o    = (state_q == ST_IDLE) && start_i;
  assign result_o = done_o ? result_q : RES_PASS;

  // R2: the command is always followed by the first read
  p_cmd_then_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we_o |=> rd_o);

  // R9: a command only follows an accepted start from idle
  p_cmd_only_from_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we_o |-> $past(start_i) && !$past(busy_o));

  // R3: read strobes are single cycle
  p_read_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_o |=> !rd_o && !cmd_we_o);

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: done only follows a sample cycle
  p_done_after_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(sample_o));

  // R10: strobes only while busy
  p_strobes_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we_o || rd_o || done_o) |-> busy_o);

endmodule

// File: rtl/nand_status_poll.sv
module nand_status_poll
  import nsp_pkg::*;
#(
  parameter int POLL_LIMIT = 100000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  output logic                 cmd_we_o,
  output logic [NSP_BUS_W-1:0] cmd_byte_o,
  output logic                 rd_o,
  input  logic [NSP_BUS_W-1:0] rd_data_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [1:0]           result_o,
  output logic [NSP_BUS_W-1:0] last_status_o
);

  localparam int CW = $clog2(POLL_LIMIT + 1);

  logic          ev_clr, ev_sample, ev_ready, ev_at_limit;
  logic [CW-1:0] rd_count;
  nsp_result_e   ev_outcome, fsm_result;

  nsp_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .ready_i    (ev_ready),
    .outcome_i  (ev_outcome),
    .at_limit_i (ev_at_limit),
    .cmd_we_o   (cmd_we_o),
    .rd_o       (rd_o),
    .sample_o   (ev_sample),
    .clr_o      (ev_clr),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (fsm_result)
  );

  nsp_poll_ctr #(.POLL_LIMIT(POLL_LIMIT)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (ev_clr),
    .inc_i      (rd_o),
    .count_o    (rd_count),
    .at_limit_o (ev_at_limit)
  );

  nsp_status_eval u_eval (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_i  (ev_sample),
    .data_i    (rd_data_i),
    .ready_o   (ev_ready),
    .outcome_o (ev_outcome),
    .last_o    (last_status_o)
  );

  assign cmd_byte_o = cmd_we_o ? NSP_CMD_STATUS : '0;
  assign result_o   = fsm_result;

  // R6: a timeout outcome only with the full read count spent
  p_timeout_at_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && result_o == RES_TIMEOUT) |-> rd_count == CW'(POLL_LIMIT));

  // R4: pass only on a ready byte with a clear error flag
  p_pass_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && result_o == RES_PASS) |-> last_status_o[NSP_READY_BIT] && !last_status_o[NSP_ERR_BIT]);

  // R5: fail only on a ready byte with the error flag set
  p_fail_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && result_o == RES_FAIL) |-> last_status_o[NSP_READY_BIT] && last_status_o[NSP_ERR_BIT]);

  // R7: no outcome code outside the done cycle, and never the unused code
  p_result_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_o |-> result_o == 2'b00) && result_o != 2'b11);

endmodule

// File: tb/nand_status_poll_tb.sv
module nand_status_poll_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 5;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       cmd_we_o, rd_o, busy_o, done_o;
  logic [7:0] cmd_byte_o, last_status_o;
  logic [7:0] rd_data_i = 8'h00;
  logic [1:0] result_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc_total = 0;
  logic [7:0] resp [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_status_poll #(.POLL_LIMIT(LIMIT)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .cmd_we_o      (cmd_we_o),
    .cmd_byte_o    (cmd_byte_o),
    .rd_o          (rd_o),
    .rd_data_i     (rd_data_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .result_o      (result_o),
    .last_status_o (last_status_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc_total, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  // n_ready = 0 means the device never becomes ready.
  task automatic run_poll(input int n_ready, input logic err, input logic [7:0] noise,
                          input logic extra_start);
    int cyc, cmds, reads, exp_reads, exp_res;
    logic [7:0] exp_last;
    for (int i = 0; i < 16; i++) begin
      logic [7:0] nz;
      nz = noise ^ 8'(i * 29);
      resp[i] = nz & 8'hBF;                       // not ready, noise elsewhere
      if (n_ready != 0 && i == n_ready - 1)
        resp[i] = (nz & 8'hBE) | 8'h40 | {7'b0, err};
    end
    exp_reads = (n_ready != 0) ? n_ready : LIMIT;
    exp_res   = (n_ready == 0) ? 2 : (err ? 1 : 0);
    exp_last  = resp[exp_reads - 1];
    cmds = 0; reads = 0; cyc = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    cyc = 1;
    while (!done_o && cyc < 200) begin
      if (cmd_we_o) begin
        cmds++;
        check("R2 command byte", cmd_byte_o, 8'h70);
        check("R2 command cycle", cyc, 1);
      end
      if (rd_o) begin
        reads++;
        check("R3 read spacing", cyc, 2 * reads);
        rd_data_i = resp[reads - 1];
      end
      if (!busy_o) check("R10 busy during poll", busy_o, 1);
      if (result_o != 2'b00) check("R7 result outside done", result_o, 0);
      start_i = (extra_start && (cyc == 3 || cyc == 4));
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    check("R7 done cycle", cyc, 2 * exp_reads + 2);
    check("R10 busy at done", busy_o, 1);
    check(n_ready == 0 ? "R6 timeout result" : (err ? "R5 fail result" : "R4 pass result"),
          result_o, exp_res);
    check(n_ready == 0 ? "R6 read count" : "R3 read count", reads, exp_reads);
    check(extra_start ? "R9 single command" : "R2 single command", cmds, 1);
    check("R8 last status", last_status_o, exp_last);
    @(negedge clk);
    check("R7 done pulse width", done_o, 0);
    check("R7 result after done", result_o, 0);
    check("R10 idle after done", busy_o, 0);
    check("R8 last status held", last_status_o, exp_last);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset cmd", cmd_we_o, 0);
    check("R1 reset read", rd_o, 0);
    check("R1 reset busy", busy_o, 0);
    check("R1 reset done", done_o, 0);
    check("R1 reset result", result_o, 0);
    check("R1 reset status", last_status_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {cmd_we_o, rd_o, busy_o, done_o}, 0);

    // R4 R5 R8: ready on every read position, both error settings, varied noise
    for (int n = 1; n <= LIMIT; n++)
      for (int e = 0; e < 2; e++)
        for (int k = 0; k < 3; k++)
          run_poll(n, e[0], 8'(8'h3C * k + 8'h81), 1'b0);

    // R6: never ready, including error-flag noise
    for (int k = 0; k < 3; k++)
      run_poll(0, 1'b1, 8'(8'hA5 + 8'h11 * k), 1'b0);

    // R9: start pulses during a running poll
    run_poll(3, 1'b0, 8'hFF, 1'b1);
    run_poll(0, 1'b0, 8'h00, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule